// File: doc/BRIEF.md
# Write Strobe and Data Launcher

This block sits between a memory command scheduler and the write data pins of a double-data-rate memory port. The scheduler raises a one-cycle start pulse and presents a four-element burst on a wide data input. After a write latency counted in clocks, the block drives the write strobe and the data bus for that burst. Each element gets one half-clock slot, and the strobe changes level at every element boundary. One low half-cycle of strobe comes before the first element (preamble) and one low half-cycle comes after the last element (postamble). Outside that window both output enables are low, which stands for a released, high-impedance bus.

All outputs are resolved into two phases per clock. Index 0 is the half-cycle that follows the rising clock edge and index 1 is the half-cycle after it, so the design needs no real DDR output cells. Starts may overlap the latency of earlier bursts. When a start follows the previous accepted start by exactly two clocks, the two bursts join into one continuous strobe train. The latency value is taken from an input while the block has no burst in flight.

Top module: `wr_strobe_launcher`

## Requirements
- R1: While reset is held, all four enable bits are 0 and both `dqs_o` and `dq_o` are all zeros.
- R2: A start accepted in cycle t with latency L drives data element 0 in phase 0 and element 1 in phase 1 of cycle t+L, and elements 2 and 3 in phases 0 and 1 of cycle t+L+1. Element k is `data_i[k*DW +: DW]` as sampled in cycle t. Phase p of the bus is `dq_o[p*DW +: DW]`.
- R3: In each data cycle the strobe is 1 in phase 0 and 0 in phase 1. Elements 0 and 2 therefore start on a rising strobe edge and elements 1 and 3 start on a falling edge.
- R4: Phase 1 of cycle t+L-1 is a preamble: strobe enable and data enable are 1, strobe is 0 and data is 0, unless that phase carries data of another burst.
- R5: Phase 0 of cycle t+L+2 is a postamble with the same values as the preamble, unless that phase carries data of another burst.
- R6: In any phase outside a preamble, data or postamble slot, both enables are 0, the strobe is 0 and the data is 0.
- R7: A start accepted two cycles after the previous accepted start makes its data follow directly. Phase 0 of cycle t+L+2 carries element 0 of the new burst with strobe 1, so no postamble or preamble shows between the two bursts.
- R8: A start accepted three cycles after the previous one puts the first burst's postamble and the second burst's preamble in the same cycle: both enables are 1 in both phases and the strobe is 0 in both.
- R9: A start pulse in the cycle directly after an accepted start is ignored and launches nothing.
- R10: The latency is `wl_i` limited to the range 2 to WL_MAX. It is sampled only in cycles preceded by WL_MAX+2 cycles without an accepted start. Otherwise the held value applies, and changes on `wl_i` have no effect.
- R11: `data_i` is sampled only in the cycle of an accepted start. Later changes do not alter the burst on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle write start pulse |
| wl_i | input | WLW | Write latency in clocks, taken while idle |
| data_i | input | 4*DW | Burst of four elements, element 0 in the low bits |
| dqs_o | output | 2 | Strobe level per phase |
| dqs_oe_o | output | 2 | Strobe drive enable per phase |
| dq_o | output | 2*DW | Data per phase, phase 0 in the low bits |
| dq_oe_o | output | 2 | Data drive enable per phase |

## Verification
Two functions can fall in one clock. With a start gap of three cycles, one burst's postamble and the next burst's preamble share a cycle. With a gap of two, a burst's postamble slot collides with the next burst's first data element, which must win. The bench provokes both cases from its vector table at several latencies, down to the minimum. It judges the shared cycle on both phases of strobe, enables and data against a model built from the start times it recorded itself. It also makes explicit checks in exactly the cycle where the overlap happens.

// File: rtl/wsl_pkg.sv
package wsl_pkg;
  localparam int unsigned BURST_LEN = 4;
  localparam int unsigned WL_MIN    = 2;

  typedef struct packed {
    logic pre;
    logic d0;
    logic d1;
    logic post;
  } slot_t;
endpackage

// File: rtl/wsl_timeline.sv
module wsl_timeline
  import wsl_pkg::*;
#(
  parameter int unsigned WL_MAX = 15,
  parameter int unsigned WLW    = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [WLW-1:0] wl_i,
  output logic           acc_o,
  output logic           busy_o,
  output logic [WLW-1:0] wl_q_o,
  output slot_t          slot_o
);
  localparam int unsigned LINE = WL_MAX + 2;
  localparam int unsigned IDXW = $clog2(LINE);

  // bit j set: a start was accepted j+1 cycles ago
  logic [LINE-1:0] line_q;
  logic [WLW-1:0]  wl_q, wl_eff;
  logic [IDXW-1:0] base;

  always_comb begin
    if (wl_i < WLW'(WL_MIN))      wl_eff = WLW'(WL_MIN);
    else if (wl_i > WLW'(WL_MAX)) wl_eff = WLW'(WL_MAX);
    else                          wl_eff = wl_i;
  end

  assign busy_o = |line_q;
  assign acc_o  = start_i & ~line_q[0];
  assign base   = IDXW'(wl_q);

  assign slot_o.pre  = line_q[base - IDXW'(2)];
  assign slot_o.d0   = line_q[base - IDXW'(1)];
  assign slot_o.d1   = line_q[base];
  assign slot_o.post = line_q[base + IDXW'(1)];
  assign wl_q_o      = wl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      wl_q   <= WLW'(WL_MIN);
    end else begin
      line_q <= {line_q[LINE-2:0], acc_o};
      if (!busy_o) wl_q <= wl_eff;
    end
  end
endmodule

// File: rtl/wsl_burst_fifo.sv
module wsl_burst_fifo
  import wsl_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    push_i,
  input  logic [BURST_LEN*DW-1:0] wdata_i,
  input  logic                    pop_i,
  output logic [BURST_LEN*DW-1:0] head_o,
  output logic [AW:0]             level_o
);
  localparam int unsigned EW    = BURST_LEN * DW;
  localparam int unsigned DEPTH = 1 << AW;

  logic [EW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   lvl_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + AW'(1);
      if (pop_i)  rd_q <= rd_q + AW'(1);
      lvl_q <= lvl_q + (AW+1)'(push_i) - (AW+1)'(pop_i);
    end
  end

  assign head_o  = mem_q[rd_q];
  assign level_o = lvl_q;
endmodule

// File: rtl/wsl_phase_mux.sv
module wsl_phase_mux
  import wsl_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  slot_t                   slot_i,
  input  logic [BURST_LEN*DW-1:0] head_i,
  output logic [1:0]              dqs_o,
  output logic [1:0]              oe_o,
  output logic [2*DW-1:0]         dq_o
);
  logic data_cyc;
  assign data_cyc = slot_i.d0 | slot_i.d1;

  for (genvar p = 0; p < 2; p++) begin : g_phase
    localparam int unsigned FIRST  = p;
    localparam int unsigned SECOND = p + 2;
    logic amble;
    if (p == 0) begin : g_post
      assign amble = slot_i.post;
    end else begin : g_pre
      assign amble = slot_i.pre;
    end
    assign oe_o[p]  = data_cyc | amble;
    // rising edge opens each data cycle, falling edge at mid-cycle
    assign dqs_o[p] = data_cyc & 1'(p == 0);
    assign dq_o[p*DW +: DW] = slot_i.d0 ? head_i[FIRST*DW +: DW]  :
                              slot_i.d1 ? head_i[SECOND*DW +: DW] : '0;
  end
endmodule

// File: rtl/wr_strobe_launcher.sv
module wr_strobe_launcher
  import wsl_pkg::*;
#(
  parameter  int unsigned DW     = 16,
  parameter  int unsigned WL_MAX = 15,
  localparam int unsigned WLW    = $clog2(WL_MAX + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [WLW-1:0]          wl_i,
  input  logic [BURST_LEN*DW-1:0] data_i,
  output logic [1:0]              dqs_o,
  output logic [1:0]              dqs_oe_o,
  output logic [2*DW-1:0]         dq_o,
  output logic [1:0]              dq_oe_o
);
  // bursts in flight never exceed WL_MAX/2 + 1
  localparam int unsigned AW = $clog2(WL_MAX / 2 + 2);

  logic                    acc, busy, pop;
  logic [WLW-1:0]          wl_q;
  slot_t                   slot;
  logic [BURST_LEN*DW-1:0] head;
  logic [AW:0]             level;
  logic [1:0]              oe;

  wsl_timeline #(.WL_MAX(WL_MAX), .WLW(WLW)) u_timeline (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .wl_i   (wl_i),
    .acc_o  (acc),
    .busy_o (busy),
    .wl_q_o (wl_q),
    .slot_o (slot)
  );

  assign pop = slot.d1;

  wsl_burst_fifo #(.DW(DW), .AW(AW)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (acc),
    .wdata_i(data_i),
    .pop_i  (pop),
    .head_o (head),
    .level_o(level)
  );

  wsl_phase_mux #(.DW(DW)) u_mux (
    .slot_i(slot),
    .head_i(head),
    .dqs_o (dqs_o),
    .oe_o  (oe),
    .dq_o  (dq_o)
  );

  assign dqs_oe_o = oe;
  assign dq_oe_o  = oe;
endmodule

// File: rtl/wr_strobe_launcher_chk.sv
module wr_strobe_launcher_chk #(
  parameter int unsigned DW  = 16,
  parameter int unsigned WLW = 4,
  parameter int unsigned AW  = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [1:0]     dqs_i,
  input logic [1:0]     dqs_oe_i,
  input logic [2*DW-1:0] dq_i,
  input logic           acc_i,
  input logic           busy_i,
  input logic [WLW-1:0] wl_q_i,
  input logic           pop_i,
  input logic [AW:0]    level_i
);
  a_r9_single_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> !acc_i);

  a_r4_pre_then_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dqs_oe_i == 2'b10) |=> (dqs_oe_i == 2'b11 && dqs_i[0]));

  a_r8_shared_then_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dqs_oe_i == 2'b11 && dqs_i == 2'b00) |=> dqs_i[0]);

  a_r5_post_after_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dqs_i[0]) && !dqs_i[0]) |-> dqs_oe_i[0]);

  a_r3_data_in_pairs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dqs_i[0]) |=> dqs_i[0]);

  a_r6_quiet_when_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dqs_oe_i == 2'b00) |-> (dq_i == '0 && dqs_i == 2'b00));

  a_r10_latency_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(wl_q_i));

  a_r2_pop_has_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (level_i != '0));
endmodule

bind wr_strobe_launcher wr_strobe_launcher_chk #(.DW(DW), .WLW(WLW), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .dqs_i   (dqs_o),
  .dqs_oe_i(dqs_oe_o),
  .dq_i    (dq_o),
  .acc_i   (acc),
  .busy_i  (busy),
  .wl_q_i  (wl_q),
  .pop_i   (pop),
  .level_i (level)
);

// File: tb/wr_strobe_launcher_tb.sv
`timescale 1ns/1ps
module wr_strobe_launcher_tb;
  import wsl_pkg::*;

  localparam int unsigned DW     = 16;
  localparam int unsigned WL_MAX = 15;
  localparam int unsigned WLW    = 4;
  localparam int unsigned EW     = BURST_LEN * DW;
  localparam int unsigned OW     = 6 + 2 * DW;
  localparam int          MAXS   = 64;
  localparam int          NV     = 9;

  // {wl_in[11:8], gap[7:4] (0 = single burst), expected latency[3:0]}
  localparam logic [11:0] VEC [NV] = '{
    {4'd2,  4'd0, 4'd2},
    {4'd5,  4'd0, 4'd5},
    {4'd0,  4'd0, 4'd2},
    {4'd3,  4'd2, 4'd3},
    {4'd4,  4'd3, 4'd4},
    {4'd6,  4'd4, 4'd6},
    {4'd2,  4'd2, 4'd2},
    {4'd15, 4'd2, 4'd15},
    {4'd7,  4'd3, 4'd7}
  };

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic [WLW-1:0] wl_i = '0;
  logic [EW-1:0]  data_i = '0;
  logic [1:0]     dqs_o, dqs_oe_o, dq_oe_o;
  logic [2*DW-1:0] dq_o;

  always #10 clk = ~clk;

  wr_strobe_launcher #(.DW(DW), .WL_MAX(WL_MAX)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .wl_i    (wl_i),
    .data_i  (data_i),
    .dqs_o   (dqs_o),
    .dqs_oe_o(dqs_oe_o),
    .dq_o    (dq_o),
    .dq_oe_o (dq_oe_o)
  );

  int cyc = 0;
  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  int            st_cyc [MAXS];
  int            st_lat [MAXS];
  logic [EW-1:0] st_dat [MAXS];
  int  nst = 0;
  int  last_acc = -1000;
  int  cur_lat = 2;
  bit  mon_on = 1'b0;
  int  n_chk = 0;
  int  n_fail = 0;

  function automatic logic [OW-1:0] outs();
    return {dqs_oe_o, dq_oe_o, dqs_o, dq_o};
  endfunction

  task automatic check(input string tag, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cyc=%0d act=%h exp=%h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] model(input int c, output string tag);
    logic [1:0]      oe, dqs;
    logic [2*DW-1:0] dq;
    oe = '0; dqs = '0; dq = '0; tag = "R6";
    for (int i = 0; i < nst; i++) begin
      if (c == st_cyc[i] + st_lat[i] - 1) begin oe[1] = 1'b1; tag = "R4 R5"; end
      if (c == st_cyc[i] + st_lat[i] + 2) begin oe[0] = 1'b1; tag = "R4 R5"; end
    end
    for (int i = 0; i < nst; i++) begin
      if (c == st_cyc[i] + st_lat[i] || c == st_cyc[i] + st_lat[i] + 1) begin
        int k;
        k = (c == st_cyc[i] + st_lat[i]) ? 0 : 2;
        oe = 2'b11; dqs = 2'b01;
        dq = st_dat[i][k*DW +: 2*DW];
        tag = "R2 R3";
      end
    end
    return {oe, oe, dqs, dq};
  endfunction

  always @(negedge clk) begin : monitor
    string t;
    logic [OW-1:0] e;
    if (mon_on) begin
      e = model(cyc, t);
      check(t, outs(), e);
    end
  end

  function automatic logic [EW-1:0] dpat(input int v, input int b);
    logic [EW-1:0] d;
    for (int k = 0; k < BURST_LEN; k++)
      d[k*DW +: DW] = DW'(16'hA000 + v * 64 + b * 16 + k * 3 + 1);
    return d;
  endfunction

  task automatic pulse(input logic [EW-1:0] d, input logic [WLW-1:0] w, input int idle_lat);
    @(negedge clk);
    start_i = 1'b1; data_i = d; wl_i = w;
    if (cyc != last_acc + 1) begin
      if (cyc - last_acc > int'(WL_MAX) + 2) cur_lat = idle_lat;
      if (nst < MAXS) begin
        st_cyc[nst] = cyc; st_lat[nst] = cur_lat; st_dat[nst] = d; nst++;
      end
      last_acc = cyc;
    end
  endtask

  task automatic quiet();
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic to_cycle(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int t;
    logic [EW-1:0] da, db;
    repeat (3) @(negedge clk);
    check("R1", outs(), '0);
    rst_ni = 1'b1;
    mon_on = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int w, g, l;
      w = int'(VEC[v][11:8]); g = int'(VEC[v][7:4]); l = int'(VEC[v][3:0]);
      da = dpat(v, 0); db = dpat(v, 1);
      pulse(da, WLW'(w), l);
      t = cyc;
      quiet();
      if (g == 0) begin
        to_cycle(t + l - 1);
        check("R4", outs(), {2'b10, 2'b10, 2'b00, {(2*DW){1'b0}}});
        to_cycle(t + l);
        check((w < 2) ? "R10" : "R2", outs(), {2'b11, 2'b11, 2'b01, da[0 +: 2*DW]});
        to_cycle(t + l + 2);
        check("R5", outs(), {2'b01, 2'b01, 2'b00, {(2*DW){1'b0}}});
        to_cycle(t + l + 3);
        check("R6", outs(), '0);
      end else begin
        to_cycle(t + g - 1);
        pulse(db, WLW'(w), l);
        quiet();
        if (g == 2) begin
          to_cycle(t + l + 2);
          check("R7", outs(), {2'b11, 2'b11, 2'b01, db[0 +: 2*DW]});
        end else if (g == 3) begin
          to_cycle(t + l + 2);
          check("R8", outs(), {2'b11, 2'b11, 2'b00, {(2*DW){1'b0}}});
        end
      end
      to_cycle(t + g + l + 25);
    end

    // R9: start in the cycle after an accepted start
    da = dpat(20, 0); db = dpat(20, 1);
    pulse(da, WLW'(4), 4);
    t = cyc;
    pulse(db, WLW'(4), 4);
    quiet();
    to_cycle(t + 5);
    check("R9", outs(), {2'b11, 2'b11, 2'b01, da[2*DW +: 2*DW]});
    to_cycle(t + 6);
    check("R9", outs(), {2'b01, 2'b01, 2'b00, {(2*DW){1'b0}}});
    to_cycle(t + 30);

    // R10: latency change while busy has no effect
    da = dpat(21, 0); db = dpat(21, 1);
    pulse(da, WLW'(3), 3);
    t = cyc;
    quiet();
    wl_i = WLW'(9);
    to_cycle(t + 3);
    pulse(db, WLW'(9), 9);
    quiet();
    to_cycle(t + 7);
    check("R10", outs(), {2'b11, 2'b11, 2'b01, db[0 +: 2*DW]});
    to_cycle(t + 35);

    // R11: data input changes after acceptance are ignored
    da = dpat(22, 0); db = dpat(22, 1);
    pulse(da, WLW'(5), 5);
    t = cyc;
    quiet();
    data_i = db;
    to_cycle(t + 5);
    check("R11", outs(), {2'b11, 2'b11, 2'b01, da[0 +: 2*DW]});
    to_cycle(t + 6);
    check("R11", outs(), {2'b11, 2'b11, 2'b01, da[2*DW +: 2*DW]});
    to_cycle(t + 30);

    mon_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule